// File: doc/BRIEF.md
# 100BASE-TX Receive Stream Framer

This block sits after the line decoder and descrambler of a 100 Mb/s twisted-pair receive path. It takes one 5-bit code-group on every 25 MHz symbol clock. From these it drives the media-independent receive signals: carrier sense, data valid, receive error and a 4-bit data nibble. It finds the stream start pair, maps data code-groups to nibbles and ends the frame on the stream end pair. It also handles the faulty cases: a stream that falls back to idle with no end pair, a start code that is not completed, and bad code-groups inside a frame.

The symbol input has no valid or ready handshake. The line delivers a new code-group on every clock and cannot be paused, so the block applies no back-pressure. The downstream MAC must take one nibble per clock. The four receive outputs are registered together. Each set of output values describes the code-group that was present at the input on the clock edge that loaded it. Code-groups are written with bit 4 as the first bit on the line.

Top module: `fxr_framer`

## Requirements
- R1: While reset is held, and on the first output cycle after it, carrier sense, data valid, receive error and the nibble are all zero.
- R2: Outside a frame, the start code 11000 gives all-zero outputs for its own cycle. If the start code is followed at once by 10001, that second code-group gives carrier sense 1, data valid 1, error 0 and nibble 0101, and the frame is open.
- R3: Inside a frame, each data code-group gives carrier sense 1, data valid 1, error 0 and its nibble, registered one clock after the symbol is sampled. The code-groups for nibbles 0 to F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R4: The end pair 01101 then 00111 closes a frame. The 01101 cycle gives carrier sense 1, data valid 0, error 0 and nibble 0. The 00111 cycle drops all outputs to zero.
- R5: Idle (11111) arriving inside a frame, or straight after 01101, drops carrier sense and data valid and raises error for exactly that one cycle, with nibble 0. Error is low again on the next cycle.
- R6: Any other code-group inside a frame (control, start or unassigned) gives carrier sense 1, data valid 1, error 1 and nibble 0, and the frame continues.
- R7: A start code followed by anything other than 10001 is a false carrier. From that next cycle onward, every cycle gives carrier sense 1, data valid 0, error 1 and nibble 1110. This lasts until an idle is seen in a later cycle; that idle cycle gives all-zero outputs.
- R8: Outside a frame, every code-group except the start code leaves all outputs at zero.
- R9: After 01101, a code-group that is neither 00111 nor idle gives carrier sense 1, data valid 1, error 1 and nibble 0, and the frame continues.
- R10: Whenever data valid is low and error is low, the nibble is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sym | input | 5 | Decoded code-group, bit 4 first on the line |
| mii_crs | output | 1 | Carrier sense |
| mii_dv | output | 1 | Receive data valid |
| mii_er | output | 1 | Receive error |
| mii_rxd | output | 4 | Receive data nibble |

## Verification
Every result is due one clock after its code-group is sampled. The bench changes the symbol on the falling edge, lets one rising edge load it, and compares all four outputs on the next falling edge against a behavioural model that has seen the same symbol. The start pair places the preamble nibble on the cycle after the second code-group. The error pulse for a premature idle is checked on its own cycle and again, as low, on the following one. The one-clock rule therefore holds for every case, including the two-symbol delimiters and the false-carrier hold.

// File: rtl/fxr_pkg.sv
package fxr_pkg;

  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] PRE_NIB = 4'b0101;
  localparam logic [NIB_W-1:0] FC_NIB  = 4'b1110;

  typedef enum logic [2:0] {
    CG_DATA, CG_IDLE, CG_J, CG_K, CG_T, CG_R, CG_BAD
  } cg_kind_e;

  typedef struct packed {
    cg_kind_e         kind;
    logic [NIB_W-1:0] nib;
  } cg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HALF, ST_FRAME, ST_TAIL, ST_FALSE
  } st_e;

  typedef struct packed {
    logic             crs;
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] rxd;
  } mii_t;

  function automatic cg_t classify(input logic [SYM_W-1:0] s);
    cg_t r;
    r.kind = CG_DATA;
    r.nib  = '0;
    case (s)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      5'b11111: r.kind = CG_IDLE;
      5'b11000: r.kind = CG_J;
      5'b10001: r.kind = CG_K;
      5'b01101: r.kind = CG_T;
      5'b00111: r.kind = CG_R;
      default:  r.kind = CG_BAD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fxr_decode.sv
module fxr_decode
  import fxr_pkg::*;
(
  input  logic [SYM_W-1:0] sym,
  output cg_t              cg
);

  always_comb cg = classify(sym);

  // R3: a data code-group never arrives without a nibble meaning; control kinds carry zero
  always_comb begin
    if (cg.kind != CG_DATA) assert (cg.nib == '0) else $error("p_ctrl_nib_zero_r3");
  end

endmodule

// File: rtl/fxr_seq.sv
module fxr_seq
  import fxr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cg_t  cg,
  output mii_t nxt
);

  st_e st, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_d;
  end

  always_comb begin
    st_d = st;
    nxt  = '0;
    unique case (st)
      ST_IDLE: begin
        if (cg.kind == CG_J) st_d = ST_HALF;
      end
      ST_HALF: begin
        nxt.crs = 1'b1;
        if (cg.kind == CG_K) begin
          st_d    = ST_FRAME;
          nxt.dv  = 1'b1;
          nxt.rxd = PRE_NIB;
        end else begin
          st_d    = ST_FALSE;
          nxt.er  = 1'b1;
          nxt.rxd = FC_NIB;
        end
      end
      ST_FRAME, ST_TAIL: begin
        if (cg.kind == CG_IDLE) begin
          st_d   = ST_IDLE;
          nxt.er = 1'b1;
        end else if (st == ST_TAIL && cg.kind == CG_R) begin
          st_d = ST_IDLE;
        end else if (st == ST_FRAME && cg.kind == CG_T) begin
          st_d    = ST_TAIL;
          nxt.crs = 1'b1;
        end else if (st == ST_FRAME && cg.kind == CG_DATA) begin
          nxt.crs = 1'b1;
          nxt.dv  = 1'b1;
          nxt.rxd = cg.nib;
        end else begin
          st_d    = ST_FRAME;
          nxt.crs = 1'b1;
          nxt.dv  = 1'b1;
          nxt.er  = 1'b1;
        end
      end
      ST_FALSE: begin
        if (cg.kind != CG_IDLE) begin
          nxt.crs = 1'b1;
          nxt.er  = 1'b1;
          nxt.rxd = FC_NIB;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // R7: the false-carrier state is left only on idle
  p_false_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FALSE && cg.kind != CG_IDLE) |=> st == ST_FALSE);

  // R4: the tail state is entered only from an open frame
  p_tail_from_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL && $past(st) != ST_TAIL) |-> $past(st) == ST_FRAME);

endmodule

// File: rtl/fxr_outreg.sv
module fxr_outreg
  import fxr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  mii_t nxt,
  output mii_t cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end

  // R3: valid data never appears without carrier
  p_dv_has_crs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cur.dv |-> cur.crs);

  // R5: the error that accompanies a carrier drop lasts one cycle
  p_er_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cur.crs) && cur.er) |=> !cur.er);

  // R10: quiet nibble when neither valid nor error
  p_rxd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur.dv && !cur.er) |-> cur.rxd == '0);

  // R2: a frame opens with the preamble nibble
  p_open_preamble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cur.crs) && cur.dv) |-> cur.rxd == PRE_NIB);

  // R7: false carrier shows its fixed nibble
  p_fc_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.crs && cur.er && !cur.dv) |-> cur.rxd == FC_NIB);

endmodule

// File: rtl/fxr_framer.sv
module fxr_framer
  import fxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] rx_sym,
  output logic             mii_crs,
  output logic             mii_dv,
  output logic             mii_er,
  output logic [NIB_W-1:0] mii_rxd
);

  cg_t  cg;
  mii_t nxt, cur;

  fxr_decode u_dec (.sym(rx_sym), .cg(cg));

  fxr_seq u_seq (.clk(clk), .rst_n(rst_n), .cg(cg), .nxt(nxt));

  fxr_outreg u_out (.clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur));

  assign mii_crs = cur.crs;
  assign mii_dv  = cur.dv;
  assign mii_er  = cur.er;
  assign mii_rxd = cur.rxd;

endmodule

// File: tb/tb_fxr_framer.sv
module tb_fxr_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rx_sym = 5'b11111;
  logic       mii_crs, mii_dv, mii_er;
  logic [3:0] mii_rxd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state: 0 outside, 1 after start code, 2 in frame, 3 after end code, 4 false carrier
  int          m_st = 0;
  logic [6:0]  exp_v;
  logic [4:0]  dcode [16];

  localparam logic [4:0] S_I = 5'b11111, S_J = 5'b11000, S_K = 5'b10001,
                         S_T = 5'b01101, S_R = 5'b00111, S_H = 5'b00100,
                         S_X = 5'b00000;

  always #5 clk = ~clk;

  fxr_framer dut (.clk(clk), .rst_n(rst_n), .rx_sym(rx_sym), .mii_crs(mii_crs),
                  .mii_dv(mii_dv), .mii_er(mii_er), .mii_rxd(mii_rxd));

  function automatic int data_of(input logic [4:0] s);
    for (int i = 0; i < 16; i++) if (dcode[i] == s) return i;
    return -1;
  endfunction

  // expected {crs,dv,er,rxd}
  function automatic logic [6:0] step(input logic [4:0] s);
    int d = data_of(s);
    logic [6:0] o = '0;
    case (m_st)
      0: if (s == S_J) m_st = 1;
      1: if (s == S_K) begin m_st = 2; o = {3'b110, 4'b0101}; end
         else begin m_st = 4; o = {3'b101, 4'b1110}; end
      2: if (s == S_I) begin m_st = 0; o = 7'b0010000; end
         else if (s == S_T) begin m_st = 3; o = 7'b1000000; end
         else if (d >= 0) o = {3'b110, 4'(d)};
         else o = 7'b1110000;
      3: if (s == S_I) begin m_st = 0; o = 7'b0010000; end
         else if (s == S_R) m_st = 0;
         else begin m_st = 2; o = 7'b1110000; end
      default: if (s == S_I) m_st = 0; else o = {3'b101, 4'b1110};
    endcase
    return o;
  endfunction

  task automatic check(input string req);
    logic [6:0] act = {mii_crs, mii_dv, mii_er, mii_rxd};
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual crs/dv/er/rxd=%b expected %b at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic send(input logic [4:0] s, input string req);
    rx_sym = s;
    exp_v  = step(s);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    dcode = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
    repeat (3) @(negedge clk);
    exp_v = '0;
    check("R1 in reset");
    rst_n = 1'b1;
    send(S_I, "R1 after reset");
    // R8: stray code-groups outside a frame
    send(S_K, "R8"); send(S_T, "R8"); send(dcode[5], "R8"); send(S_H, "R8");
    send(S_R, "R8"); send(S_I, "R8");
    // R2 and R3: full frame with every nibble, then R4 clean end
    send(S_J, "R2 start code cycle");
    send(S_K, "R2 preamble");
    for (int i = 0; i < 16; i++) send(dcode[i], "R3 nibble map");
    send(S_T, "R4 end code");
    send(S_R, "R4 carrier drop");
    send(S_I, "R4 idle after end");
    // R5 premature idle
    send(S_J, "R2"); send(S_K, "R2");
    send(dcode[10], "R3"); send(dcode[3], "R3");
    send(S_I, "R5 error pulse");
    send(S_I, "R5 error gone");
    // R6 bad code-groups inside a frame; R9 end code then junk
    send(S_J, "R2"); send(S_K, "R2");
    send(S_X, "R6 unassigned"); send(S_H, "R6 control"); send(S_J, "R6 start in frame");
    send(dcode[7], "R3");
    send(S_T, "R4"); send(dcode[2], "R9 after end code");
    send(dcode[9], "R9 frame goes on");
    send(S_T, "R4"); send(S_I, "R5 idle after end code");
    send(S_I, "R5 error gone");
    // R7 false carrier
    send(S_J, "R7 start code"); send(dcode[1], "R7 not K");
    send(dcode[4], "R7 hold"); send(S_K, "R7 hold"); send(S_I, "R7 released");
    send(S_I, "R10");
    send(S_J, "R7"); send(S_I, "R7 idle as second code");
    send(S_I, "R7 released");
    // R1 reset mid-frame
    send(S_J, "R2"); send(S_K, "R2");
    rst_n = 1'b0; m_st = 0; exp_v = '0;
    @(negedge clk); check("R1 reset mid-frame");
    rst_n = 1'b1;
    send(dcode[6], "R1 stays outside frame");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule